// File: doc/BRIEF.md
# Return-From-Interrupt Sequencer

This block is the multicycle control unit that carries out a privileged return from an interrupt service routine. Once started, it first confirms that the processor is in supervisor mode. It then pops two words from the supervisor stack, whose top is held in stack-pointer register R6. The first word becomes the program counter and the second becomes the processor status word. If the restored status word says the processor is going back to user mode, R6 is then reloaded from the saved user stack pointer. If the operation is requested while the processor is already in user mode, nothing is popped, no state changes, and a privilege exception is raised.

Instruction decode drives the block with a one-cycle start request. The block reads the current PC, PSR, R6 and saved user stack pointer on input ports, and updates the PC, PSR and R6 through write strobes with data. Stack words come from a single-port word memory. The block asks for one read at a time and waits for that read's valid signal. The status word keeps privilege in bit 15, priority level in bits [10:8] and the N, Z and P condition flags in bits [2:0]. The sequencer restores the whole word unchanged.

Top module: `irq_return_seq`

## Requirements
- R1: Out of reset, and whenever no operation is in progress, `busy`, `done`, `exc`, `mem_req`, `pc_we`, `psr_we` and `sp_we` are all low.
- R2: If bit 15 of `psr_q` is 1 when the privilege check runs, `exc` pulses high for one cycle. No memory read is issued, none of `pc_we`, `psr_we` or `sp_we` is asserted, and `done` stays low.
- R3: The first read goes to the address held in R6. The PC is written with the returned word, and only in the cycle where `mem_rvalid` is high.
- R4: The second read goes to R6 + 1. The PSR is written with the returned word, all 16 bits unchanged, in the cycle where that read is valid.
- R5: If bit 15 of the restored PSR is 0, R6 ends the operation at its starting value + 2.
- R6: If bit 15 of the restored PSR is 1, R6 ends the operation equal to `saved_usp`.
- R7: Only one read is outstanding at a time. `mem_req` and `mem_addr` stay unchanged until `mem_rvalid`, for any memory latency, and exactly two reads are made per successful operation.
- R8: After the last register update, `done` pulses high for exactly one cycle, and `exc` stays low.
- R9: A `start` that arrives while an operation is in progress is ignored, so no extra reads and no second `done` occur.
- R10: Stack-pointer arithmetic wraps modulo 2^16. Starting from R6 = 0xFFFF, the reads go to 0xFFFF and then 0x0000, and R6 ends at 0x0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a return |
| psr_q | input | 16 | Current processor status word |
| sp_q | input | 16 | Current R6 (supervisor stack pointer) |
| saved_usp | input | 16 | Saved user stack pointer |
| mem_req | output | 1 | Memory read request, held until valid |
| mem_addr | output | 16 | Memory read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 16 | Read data |
| pc_we | output | 1 | PC write strobe |
| pc_wdata | output | 16 | New PC value |
| psr_we | output | 1 | PSR write strobe |
| psr_wdata | output | 16 | New PSR value |
| sp_we | output | 1 | R6 write strobe |
| sp_wdata | output | 16 | New R6 value |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| exc | output | 1 | One-cycle privilege exception pulse |

## Verification
The hardest situation to reach from the ports is a second `start` that lands while a stack read is still waiting for its valid. Only then can a restart bug cause a third read or a second completion. The bench reaches it by holding the memory response back for a random number of cycles and pulsing `start` again in the middle of the operation. It then runs the same case against the pointer wrap at 0xFFFF and against both settings of the restored privilege bit, so that both the swap path and the no-swap path are hit while a request is pending.

// File: rtl/rti_pkg.sv
package rti_pkg;
  localparam int unsigned WORD_W   = 16;
  localparam int unsigned PRIV_POS = 15;
  localparam int unsigned POP_STEP = 1;

  typedef logic [WORD_W-1:0] word_t;

  localparam word_t PRIV_MASK = word_t'(1) << PRIV_POS;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_POP_PC,
    ST_POP_PSR,
    ST_RESTORE_SP,
    ST_DONE,
    ST_EXCEPT
  } rti_state_e;

  // Stack grows downward, so a pop moves the pointer up by one word.
  function automatic word_t ptr_after_pop(word_t p);
    return p + word_t'(POP_STEP);
  endfunction

  // Privilege field set means the word describes user mode.
  function automatic logic is_user_mode(word_t psr);
    return |(psr & PRIV_MASK);
  endfunction
endpackage

// File: rtl/rti_ctrl.sv
module rti_ctrl
  import rti_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       cur_user,
  input  logic       rd_valid,
  input  logic       popped_user,
  output rti_state_e state_q
);
  rti_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:       if (start) state_d = ST_CHECK;
      ST_CHECK:      state_d = cur_user ? ST_EXCEPT : ST_POP_PC;
      ST_POP_PC:     if (rd_valid) state_d = ST_POP_PSR;
      ST_POP_PSR:    if (rd_valid) state_d = popped_user ? ST_RESTORE_SP : ST_DONE;
      ST_RESTORE_SP: state_d = ST_DONE;
      ST_DONE:       state_d = ST_IDLE;
      ST_EXCEPT:     state_d = ST_IDLE;
      default:       state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/rti_ptr_unit.sv
module rti_ptr_unit
  import rti_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load_en,
  input  word_t load_val,
  input  logic  step_en,
  output word_t ptr_q,
  output word_t ptr_nx
);
  assign ptr_nx = ptr_after_pop(ptr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr_q <= '0;
    else if (load_en) ptr_q <= load_val;
    else if (step_en) ptr_q <= ptr_nx;
  end
endmodule

// File: rtl/irq_return_seq.sv
module irq_return_seq
  import rti_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [15:0] psr_q,
  input  logic [15:0] sp_q,
  input  logic [15:0] saved_usp,
  output logic        mem_req,
  output logic [15:0] mem_addr,
  input  logic        mem_rvalid,
  input  logic [15:0] mem_rdata,
  output logic        pc_we,
  output logic [15:0] pc_wdata,
  output logic        psr_we,
  output logic [15:0] psr_wdata,
  output logic        sp_we,
  output logic [15:0] sp_wdata,
  output logic        busy,
  output logic        done,
  output logic        exc
);
  rti_state_e state_q;
  word_t      ptr_q;
  word_t      ptr_nx;

  // Named internal events, also observed by the bound checker.
  logic cur_user;
  logic popped_user;
  logic ev_enter_check;
  logic ev_priv_fault;
  logic ev_pc_popped;
  logic ev_psr_popped;
  logic ev_usp_swap;

  assign cur_user       = is_user_mode(psr_q);
  assign popped_user    = is_user_mode(mem_rdata);
  assign ev_enter_check = (state_q == ST_CHECK);
  assign ev_priv_fault  = ev_enter_check && cur_user;
  assign ev_pc_popped   = (state_q == ST_POP_PC)  && mem_rvalid;
  assign ev_psr_popped  = (state_q == ST_POP_PSR) && mem_rvalid;
  assign ev_usp_swap    = (state_q == ST_RESTORE_SP);

  rti_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .cur_user    (cur_user),
    .rd_valid    (mem_rvalid),
    .popped_user (popped_user),
    .state_q     (state_q)
  );

  rti_ptr_unit u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (ev_enter_check),
    .load_val (sp_q),
    .step_en  (ev_pc_popped || ev_psr_popped),
    .ptr_q    (ptr_q),
    .ptr_nx   (ptr_nx)
  );

  assign mem_req   = (state_q == ST_POP_PC) || (state_q == ST_POP_PSR);
  assign mem_addr  = ptr_q;
  assign pc_we     = ev_pc_popped;
  assign pc_wdata  = mem_rdata;
  assign psr_we    = ev_psr_popped;
  assign psr_wdata = mem_rdata;
  assign sp_we     = ev_pc_popped || ev_psr_popped || ev_usp_swap;
  assign sp_wdata  = ev_usp_swap ? saved_usp : ptr_nx;
  assign busy      = (state_q != ST_IDLE);
  assign done      = (state_q == ST_DONE);
  assign exc       = (state_q == ST_EXCEPT);
endmodule

// File: rtl/rti_checker.sv
module rti_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        exc,
  input logic        mem_req,
  input logic [15:0] mem_addr,
  input logic        mem_rvalid,
  input logic [15:0] mem_rdata,
  input logic        pc_we,
  input logic [15:0] pc_wdata,
  input logic        psr_we,
  input logic [15:0] psr_wdata,
  input logic        sp_we,
  input logic [15:0] sp_wdata,
  input logic        ev_priv_fault,
  input logic        ev_pc_popped
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req && !pc_we && !psr_we && !sp_we && !done && !exc);

  p_fault_raises_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_priv_fault |=> exc);

  p_exc_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    exc |-> !mem_req && !pc_we && !psr_we && !sp_we && !done);

  p_exc_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    exc |=> !exc);

  p_pc_from_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we |-> mem_req && mem_rvalid && (pc_wdata == mem_rdata));

  p_psr_from_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    psr_we |-> mem_req && mem_rvalid && (psr_wdata == mem_rdata));

  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rvalid |=> mem_req && $stable(mem_addr));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !exc && !mem_req && !sp_we);

  p_ptr_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pc_popped |-> sp_we && (sp_wdata == mem_addr + 16'd1));
endmodule

bind irq_return_seq rti_checker u_rti_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .busy          (busy),
  .done          (done),
  .exc           (exc),
  .mem_req       (mem_req),
  .mem_addr      (mem_addr),
  .mem_rvalid    (mem_rvalid),
  .mem_rdata     (mem_rdata),
  .pc_we         (pc_we),
  .pc_wdata      (pc_wdata),
  .psr_we        (psr_we),
  .psr_wdata     (psr_wdata),
  .sp_we         (sp_we),
  .sp_wdata      (sp_wdata),
  .ev_priv_fault (ev_priv_fault),
  .ev_pc_popped  (ev_pc_popped)
);

// File: tb/tb_irq_return_seq.sv
`timescale 1ns/1ps
module tb_irq_return_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] psr_q, sp_q, saved_usp = 16'h0;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [15:0] mem_rdata = 16'h0;
  logic        pc_we, psr_we, sp_we;
  logic [15:0] pc_wdata, psr_wdata, sp_wdata;
  logic        busy, done, exc;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  irq_return_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .psr_q(psr_q), .sp_q(sp_q), .saved_usp(saved_usp),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .pc_we(pc_we), .pc_wdata(pc_wdata),
    .psr_we(psr_we), .psr_wdata(psr_wdata),
    .sp_we(sp_we), .sp_wdata(sp_wdata),
    .busy(busy), .done(done), .exc(exc)
  );

  // Architectural register model plus event counters.
  logic        preset_en = 1'b0;
  logic [15:0] p_pc = 0, p_psr = 0, p_sp = 0;
  logic [15:0] pc_r;
  int done_cnt, exc_cnt, pcw_cnt, psrw_cnt;

  assign psr_q = psr_r;
  assign sp_q  = sp_r;
  logic [15:0] psr_r, sp_r;

  always @(posedge clk) begin
    if (preset_en) begin
      pc_r <= p_pc; psr_r <= p_psr; sp_r <= p_sp;
      done_cnt <= 0; exc_cnt <= 0; pcw_cnt <= 0; psrw_cnt <= 0;
    end else begin
      if (pc_we)  begin pc_r  <= pc_wdata;  pcw_cnt  <= pcw_cnt + 1;  end
      if (psr_we) begin psr_r <= psr_wdata; psrw_cnt <= psrw_cnt + 1; end
      if (sp_we)  sp_r <= sp_wdata;
      if (done)   done_cnt <= done_cnt + 1;
      if (exc)    exc_cnt  <= exc_cnt + 1;
    end
  end

  // Memory responder with configurable latency.
  logic [15:0] m_base = 0, m_pc = 0, m_psr = 0;
  int          lat_cfg = 0;
  int          wait_cnt = 0;
  int          rd_cnt = 0;
  logic [15:0] rd_addr0 = 0, rd_addr1 = 0;

  initial begin
    forever begin
      @(negedge clk);
      if (preset_en) begin rd_cnt = 0; rd_addr0 = 16'h0; rd_addr1 = 16'h0; end
      if (mem_rvalid) begin
        mem_rvalid = 1'b0;
        wait_cnt = lat_cfg;
      end else if (mem_req) begin
        if (wait_cnt <= 0) begin
          mem_rvalid = 1'b1;
          if (mem_addr == m_base)              mem_rdata = m_pc;
          else if (mem_addr == m_base + 16'd1) mem_rdata = m_psr;
          else                                 mem_rdata = 16'hDEAD;
          if (rd_cnt == 0) rd_addr0 = mem_addr;
          if (rd_cnt == 1) rd_addr1 = mem_addr;
          rd_cnt++;
        end else begin
          wait_cnt--;
        end
      end else begin
        wait_cnt = lat_cfg;
      end
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Expected final values, derived from the requirements.
  function automatic logic [15:0] exp_sp(logic [15:0] cur, logic [15:0] sp0,
                                         logic [15:0] usp, logic [15:0] pv);
    if (cur[15])  return sp0;
    if (pv[15])   return usp;
    return 16'(sp0 + 16'd2);
  endfunction

  task automatic run_op(input logic [15:0] cur, input logic [15:0] sp0,
                        input logic [15:0] usp, input logic [15:0] pcv,
                        input logic [15:0] psv, input int lat, input bit restart);
    logic [15:0] old_pc;
    int cyc;
    bit fault;
    fault  = cur[15];
    old_pc = 16'h1234;
    @(negedge clk);
    preset_en = 1'b1; p_pc = old_pc; p_psr = cur; p_sp = sp0;
    m_base = sp0; m_pc = pcv; m_psr = psv; lat_cfg = lat; saved_usp = usp;
    @(negedge clk);
    preset_en = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!(done || exc) && cyc < 200) begin
      if (restart && cyc == 2) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cyc++;
    end
    if (cyc >= 200) chk("R8", "completion seen", 16'h0, 16'h1);
    @(negedge clk);
    chk("R8", "pulse ended", {13'h0, done, exc, busy}, 16'h0);
    repeat (3) @(negedge clk);
    chk("R9", "idle after op", {15'h0, busy}, 16'h0);
    if (fault) begin
      chk("R2", "exception count", 16'(exc_cnt), 16'd1);
      chk("R2", "reads", 16'(rd_cnt), 16'd0);
      chk("R2", "pc kept", pc_r, old_pc);
      chk("R2", "psr kept", psr_r, cur);
      chk("R2", "sp kept", sp_r, sp0);
      chk("R2", "no done", 16'(done_cnt), 16'd0);
    end else begin
      chk("R3", "pc restored", pc_r, pcv);
      chk("R3", "first address", rd_addr0, sp0);
      chk("R4", "psr restored", psr_r, psv);
      chk("R4", "second address", rd_addr1, 16'(sp0 + 16'd1));
      chk(psv[15] ? "R6" : "R5", "final sp", sp_r, exp_sp(cur, sp0, usp, psv));
      chk("R7", "read count", 16'(rd_cnt), 16'd2);
      chk("R8", "done count", 16'(done_cnt), 16'd1);
      chk("R8", "no exception", 16'(exc_cnt), 16'd0);
      chk("R3", "pc writes", 16'(pcw_cnt), 16'd1);
    end
  endtask

  int cycles = 0;
  always @(posedge clk) cycles <= cycles + 1;

  initial begin
    wait (cycles >= 150000);
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1", "reset outputs",
        {9'h0, busy, done, exc, mem_req, pc_we, psr_we, sp_we}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "idle outputs",
        {9'h0, busy, done, exc, mem_req, pc_we, psr_we, sp_we}, 16'h0);

    // Directed corners.
    run_op(16'h8002, 16'h3000, 16'hFE00, 16'h4000, 16'h0001, 1, 1'b0); // R2 user-mode attempt
    run_op(16'h0402, 16'h2FF0, 16'hFD00, 16'h3100, 16'h0704, 0, 1'b0); // R5 stay supervisor
    run_op(16'h0001, 16'h2FF0, 16'hFD00, 16'h3100, 16'h8302, 3, 1'b0); // R6 swap to user stack
    run_op(16'h0000, 16'hFFFF, 16'hC000, 16'h5555, 16'h0002, 2, 1'b0); // R10 wrap
    run_op(16'h0000, 16'hFFFF, 16'hC000, 16'hAAAA, 16'h8001, 4, 1'b1); // R9 restart during wait
    run_op(16'h0000, 16'h4000, 16'h1111, 16'h2222, 16'h0000, 5, 1'b1); // R7 long latency

    for (int i = 0; i < 60; i++) begin
      logic [15:0] cur, psv;
      cur = 16'($urandom);
      cur[15] = ($urandom % 5) == 0;
      psv = 16'($urandom);
      run_op(cur, 16'($urandom), 16'($urandom), 16'($urandom), psv,
             int'($urandom % 6), bit'($urandom % 3 == 0));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule